// File: doc/BRIEF.md
# Viterbi Path-Metric Update Step

This block advances the path metrics of a Viterbi decoder by one trellis step. It keeps the metric of every trellis state in its own registers. Each accepted step pairs old states 2j and 2j+1 into butterfly j, applies that butterfly's signed branch metric, and keeps the larger candidate for each of the two new states it feeds. One survivor decision bit per new state goes out for an external traceback memory. The trellis size follows from the constraint-length parameter: 16 states for constraint length 5, or 64 states for constraint length 7. All butterflies of a step are evaluated in parallel.

Metrics grow without bound under maximisation, so each step can carry a normalize request. When it is set, the smallest of the freshly computed metrics is subtracted from all of them before they are stored. This costs one extra cycle. Branch-metric generation and traceback live outside the block.

Top module: `viterbi_acs_step`

## Requirements
- R1: A synchronous reset sets state 0 to metric 0 and every other state to -32768 (0x8000). It also clears `dec_out` and `done`.
- R2: Metrics are signed 16-bit. State i sits at `pm_out[16i+15:16i]`, and the branch metric of butterfly j at `bm_in[16j+15:16j]`. Butterfly j takes old state 2j as its even operand and old state 2j+1 as its odd operand.
- R3: With b as the branch metric, new state j receives max(even+b, odd-b), and new state j+S/2 receives max(even-b, odd+b). S is the state count.
- R4: All four candidate sums saturate to the signed 16-bit range [-32768, 32767] instead of wrapping.
- R5: `dec_out[i]` is 1 when the candidate sourced from the even operand is greater than or equal to the one sourced from the odd operand. A tie therefore gives 1.
- R6: When `norm_req` is high with an accepted step, the minimum of the new metrics is subtracted from every new metric with saturation. The stored result therefore contains a 0 and no negative value.
- R7: A step without normalization stores its results and pulses `done` on the first clock edge after the accepted `in_valid`. A normalized step does so on the second edge, and `done` stays low at the first.
- R8: `pm_out` and `dec_out` change only on cycles where `done` is presented. Between steps they hold regardless of `bm_in` and `norm_req`.
- R9: An `in_valid` seen during the extra normalization cycle is ignored. It starts no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Starts one trellis step with the present branch metrics |
| norm_req | input | 1 | Normalize the metrics of this step |
| bm_in | input | 16*S/2 | Signed branch metric per butterfly |
| pm_out | output | 16*S | Stored signed path metric per state |
| dec_out | output | S | Survivor decision per new state |
| done | output | 1 | One-cycle pulse when a step's results are stored |

## Verification
The bench builds the default constraint length of 5, which gives 16 states and 8 butterflies. At that size every stored metric and every decision bit can be compared against an arithmetic model after every step. The sweep then covers hundreds of steps with mixed small and full-scale branch metrics and interleaved normalize requests. Directed steps reach the reset pattern and all-tie decisions. They also drive metrics into positive and negative saturation, normalize right after saturation, and hold `in_valid` high through the normalization cycle.

// File: rtl/vacs_pkg.sv
package vacs_pkg;
  localparam int METRIC_W = 16;
  typedef logic signed [METRIC_W-1:0] metric_t;
  typedef logic signed [METRIC_W:0]   wide_t;

  localparam metric_t METRIC_MAX = metric_t'({1'b0, {(METRIC_W-1){1'b1}}});
  localparam metric_t METRIC_MIN = metric_t'({1'b1, {(METRIC_W-1){1'b0}}});

  // Clamp a one-bit-wider result into metric range.
  function automatic metric_t clamp_wide(input wide_t w);
    if (w[METRIC_W] != w[METRIC_W-1])
      return w[METRIC_W] ? METRIC_MIN : METRIC_MAX;
    return metric_t'(w[METRIC_W-1:0]);
  endfunction

  function automatic metric_t sat_add(input metric_t a, input metric_t b);
    wide_t w;
    w = wide_t'({a[METRIC_W-1], a}) + wide_t'({b[METRIC_W-1], b});
    return clamp_wide(w);
  endfunction

  function automatic metric_t sat_sub(input metric_t a, input metric_t b);
    wide_t w;
    w = wide_t'({a[METRIC_W-1], a}) - wide_t'({b[METRIC_W-1], b});
    return clamp_wide(w);
  endfunction

  // Survivor rule: even-sourced candidate wins ties.
  function automatic logic keep_even(input metric_t from_even, input metric_t from_odd);
    return from_even >= from_odd;
  endfunction

  function automatic metric_t lesser(input metric_t a, input metric_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/vacs_butterfly.sv
module vacs_butterfly
  import vacs_pkg::*;
(
  input  metric_t even_pm,
  input  metric_t odd_pm,
  input  metric_t bm,
  output metric_t low_pm,
  output metric_t high_pm,
  output logic    low_dec,
  output logic    high_dec
);
  metric_t cand_even_plus;
  metric_t cand_odd_minus;
  metric_t cand_even_minus;
  metric_t cand_odd_plus;

  assign cand_even_plus  = sat_add(even_pm, bm);
  assign cand_odd_minus  = sat_sub(odd_pm, bm);
  assign cand_even_minus = sat_sub(even_pm, bm);
  assign cand_odd_plus   = sat_add(odd_pm, bm);

  // new state j
  assign low_dec  = keep_even(cand_even_plus, cand_odd_minus);
  assign low_pm   = low_dec ? cand_even_plus : cand_odd_minus;
  // new state j + S/2
  assign high_dec = keep_even(cand_even_minus, cand_odd_plus);
  assign high_pm  = high_dec ? cand_even_minus : cand_odd_plus;
endmodule

// File: rtl/vacs_min_tree.sv
module vacs_min_tree
  import vacs_pkg::*;
#(
  parameter int N = 16
) (
  input  metric_t vals [N],
  output metric_t min_val
);
  localparam int NODES = 2 * N - 1;

  // Heap-ordered comparison tree: leaves at N-1..2N-2, root at 0.
  metric_t node [NODES];

  always_comb begin
    for (int i = 0; i < N; i++) node[N-1+i] = vals[i];
    for (int i = N - 2; i >= 0; i--) node[i] = lesser(node[2*i+1], node[2*i+2]);
  end

  assign min_val = node[0];
endmodule

// File: rtl/vacs_normalizer.sv
module vacs_normalizer
  import vacs_pkg::*;
#(
  parameter int N = 16
) (
  input  metric_t raw [N],
  output metric_t floor_val,
  output metric_t adj [N]
);
  vacs_min_tree #(.N(N)) u_min (
    .vals    (raw),
    .min_val (floor_val)
  );

  for (genvar i = 0; i < N; i++) begin : g_sub
    assign adj[i] = sat_sub(raw[i], floor_val);
  end
endmodule

// File: rtl/viterbi_acs_step.sv
module viterbi_acs_step
  import vacs_pkg::*;
#(
  parameter  int CONSTR_LEN = 5,
  localparam int NUM_STATES = 1 << (CONSTR_LEN - 1),
  localparam int NUM_BFLY   = NUM_STATES / 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic                           norm_req,
  input  logic [NUM_BFLY*METRIC_W-1:0]   bm_in,
  output logic [NUM_STATES*METRIC_W-1:0] pm_out,
  output logic [NUM_STATES-1:0]          dec_out,
  output logic                           done
);
  // Stored metrics, staged metrics awaiting normalization
  metric_t pm_q    [NUM_STATES];
  metric_t stg_pm  [NUM_STATES];
  metric_t acs_pm  [NUM_STATES];
  metric_t norm_pm [NUM_STATES];
  metric_t bm_lane [NUM_BFLY];
  metric_t norm_floor;

  logic [NUM_STATES-1:0] acs_dec;
  logic [NUM_STATES-1:0] stg_dec;
  logic [NUM_STATES-1:0] dec_q;
  logic pend_q;
  logic done_q;

  // Named step events
  logic take_step;
  logic take_plain;
  logic take_norm;

  assign take_step  = in_valid & ~pend_q;
  assign take_plain = take_step & ~norm_req;
  assign take_norm  = take_step & norm_req;

  for (genvar j = 0; j < NUM_BFLY; j++) begin : g_bfly
    assign bm_lane[j] = metric_t'(bm_in[j*METRIC_W +: METRIC_W]);
    vacs_butterfly u_bf (
      .even_pm  (pm_q[2*j]),
      .odd_pm   (pm_q[2*j+1]),
      .bm       (bm_lane[j]),
      .low_pm   (acs_pm[j]),
      .high_pm  (acs_pm[j+NUM_BFLY]),
      .low_dec  (acs_dec[j]),
      .high_dec (acs_dec[j+NUM_BFLY])
    );
  end

  vacs_normalizer #(.N(NUM_STATES)) u_norm (
    .raw       (stg_pm),
    .floor_val (norm_floor),
    .adj       (norm_pm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_STATES; i++) begin
        pm_q[i]   <= (i == 0) ? metric_t'(0) : METRIC_MIN;
        stg_pm[i] <= metric_t'(0);
      end
      dec_q   <= '0;
      stg_dec <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= take_plain | pend_q;
      pend_q <= take_norm;
      if (pend_q) begin
        pm_q  <= norm_pm;
        dec_q <= stg_dec;
      end else if (take_plain) begin
        pm_q  <= acs_pm;
        dec_q <= acs_dec;
      end
      if (take_norm) begin
        stg_pm  <= acs_pm;
        stg_dec <= acs_dec;
      end
    end
  end

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_out
    assign pm_out[i*METRIC_W +: METRIC_W] = pm_q[i];
  end
  assign dec_out = dec_q;
  assign done    = done_q;
endmodule

// File: rtl/viterbi_acs_step_chk.sv
module viterbi_acs_step_chk
  import vacs_pkg::*;
#(
  parameter int NUM_STATES = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           in_valid,
  input logic                           norm_req,
  input logic                           pend_q,
  input logic                           done,
  input logic [NUM_STATES*METRIC_W-1:0] pm_out,
  input logic [NUM_STATES-1:0]          dec_out
);
  logic [NUM_STATES*METRIC_W-1:0] reset_pat;
  logic any_zero;
  logic all_nonneg;

  always_comb begin
    any_zero   = 1'b0;
    all_nonneg = 1'b1;
    for (int i = 0; i < NUM_STATES; i++) begin
      reset_pat[i*METRIC_W +: METRIC_W] = (i == 0) ? '0 : METRIC_MIN;
      if (pm_out[i*METRIC_W +: METRIC_W] == '0) any_zero = 1'b1;
      if (pm_out[i*METRIC_W + METRIC_W - 1]) all_nonneg = 1'b0;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pm_out == reset_pat && !done && dec_out == '0));

  a_r7_plain_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !norm_req && !pend_q) |=> done);

  a_r7_norm_two_cycles: assert property (@(posedge clk) disable iff (rst)
    (in_valid && norm_req && !pend_q) |=> (!done && pend_q) ##1 done);

  a_r7_done_has_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(pend_q) || $past(in_valid && !norm_req && !pend_q)));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pm_out) && $stable(dec_out)));

  a_r6_norm_has_zero: assert property (@(posedge clk) disable iff (rst)
    (done && $past(pend_q)) |-> any_zero);

  a_r6_norm_nonneg: assert property (@(posedge clk) disable iff (rst)
    (done && $past(pend_q)) |-> all_nonneg);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> !pend_q);
endmodule

bind viterbi_acs_step viterbi_acs_step_chk #(.NUM_STATES(NUM_STATES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .norm_req (norm_req),
  .pend_q   (pend_q),
  .done     (done),
  .pm_out   (pm_out),
  .dec_out  (dec_out)
);

// File: tb/viterbi_acs_step_bench.sv
module viterbi_acs_step_bench;
  localparam int CL = 5;
  localparam int S  = 16;
  localparam int NB = 8;
  localparam int W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic norm_req = 1'b0;
  logic [NB*W-1:0] bm_in = '0;
  logic [S*W-1:0]  pm_out;
  logic [S-1:0]    dec_out;
  logic            done;

  viterbi_acs_step #(.CONSTR_LEN(CL)) u_viterbi_acs_step (
    .clk(clk), .rst(rst), .in_valid(in_valid), .norm_req(norm_req),
    .bm_in(bm_in), .pm_out(pm_out), .dec_out(dec_out), .done(done)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int mdl [S];
  logic [S-1:0] mdl_dec;
  int bms [NB];
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(input bit ok, input string what, input logic [S*W-1:0] act,
                     input logic [S*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [S*W-1:0] pack_mdl();
    logic [S*W-1:0] r;
    for (int i = 0; i < S; i++) r[i*W +: W] = 16'(mdl[i]);
    return r;
  endfunction

  // Arithmetic restatement of one step on the model.
  function automatic void model_step(input bit norm);
    int nw [S];
    logic [S-1:0] dv;
    int mn;
    for (int j = 0; j < NB; j++) begin
      int e, o, b, p, q;
      e = mdl[2*j]; o = mdl[2*j+1]; b = bms[j];
      p = sat16(e + b); q = sat16(o - b);
      dv[j] = (p >= q); nw[j] = (p >= q) ? p : q;
      p = sat16(e - b); q = sat16(o + b);
      dv[j+NB] = (p >= q); nw[j+NB] = (p >= q) ? p : q;
    end
    if (norm) begin
      mn = nw[0];
      for (int i = 1; i < S; i++) if (nw[i] < mn) mn = nw[i];
      for (int i = 0; i < S; i++) nw[i] = sat16(nw[i] - mn);
    end
    for (int i = 0; i < S; i++) mdl[i] = nw[i];
    mdl_dec = dv;
  endfunction

  task automatic drive_bm();
    for (int j = 0; j < NB; j++) bm_in[j*W +: W] = 16'(bms[j]);
  endtask

  task automatic check_results(input string tag);
    chk(done == 1'b1, {tag, " R7 done"}, S*W'(done), S*W'(1));
    chk(pm_out == pack_mdl(), {tag, " R2 R3 R4 metrics"}, pm_out, pack_mdl());
    chk(dec_out == mdl_dec, {tag, " R5 decisions"}, S*W'(dec_out), S*W'(mdl_dec));
  endtask

  // One step; inputs change at negedges, outputs sampled at negedges.
  task automatic run_step(input bit norm, input bit poke, input string tag);
    logic [S*W-1:0] held;
    drive_bm();
    norm_req = norm;
    in_valid = 1'b1;
    @(negedge clk);
    if (!norm) begin
      in_valid = 1'b0;
      model_step(1'b0);
      check_results(tag);
    end else begin
      chk(done == 1'b0, {tag, " R7 no done in first cycle"}, S*W'(done), '0);
      model_step(1'b1);
      if (poke) begin
        for (int j = 0; j < NB; j++) bms[j] = 5000 - 1000 * j;
        drive_bm();
        norm_req = 1'b0;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b0;
      check_results(tag);
      if (poke) begin
        held = pm_out;
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 ignored valid gives no done"}, S*W'(done), '0);
        chk(pm_out == held, {tag, " R9 metrics untouched"}, pm_out, held);
      end
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R7 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [S*W-1:0] held_pm;
    logic [S-1:0]   held_dec;
    bit has_zero;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset pattern
    mdl[0] = 0;
    for (int i = 1; i < S; i++) mdl[i] = -32768;
    chk(pm_out == pack_mdl(), "R1 reset metrics", pm_out, pack_mdl());
    chk(done == 1'b0, "R1 done low", S*W'(done), '0);
    chk(dec_out == '0, "R1 decisions clear", S*W'(dec_out), '0);

    // R5: zero branch metrics, ties everywhere except butterfly 0
    for (int j = 0; j < NB; j++) bms[j] = 0;
    run_step(1'b0, 1'b0, "tie");
    chk(dec_out == '1, "R5 ties pick even", S*W'(dec_out), S*W'({S{1'b1}}));

    // R2/R3: distinct branch metric per lane
    for (int j = 0; j < NB; j++) bms[j] = 100 * (j + 1) - 350;
    run_step(1'b0, 1'b0, "lanes");
    for (int j = 0; j < NB; j++) bms[j] = (j % 2 == 0) ? 77 * j : -53 * j;
    run_step(1'b0, 1'b0, "lanes2");

    // R8: idle with changing inputs
    held_pm = pm_out;
    held_dec = dec_out;
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < NB; j++) bms[j] = 999 * (k + 1) + j;
      drive_bm();
      norm_req = k[0];
      @(negedge clk);
      chk(done == 1'b0, "R8 no done when idle", S*W'(done), '0);
      chk(pm_out == held_pm, "R8 metrics hold", pm_out, held_pm);
      chk(dec_out == held_dec, "R8 decisions hold", S*W'(dec_out), S*W'(held_dec));
    end

    // R4: drive into positive then negative saturation
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < NB; j++) bms[j] = 30000;
      run_step(1'b0, 1'b0, "sat_pos");
    end
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < NB; j++) bms[j] = -32768 + j;
      run_step(1'b0, 1'b0, "sat_neg");
    end

    // R6: normalize after saturation
    for (int j = 0; j < NB; j++) bms[j] = 1234 - 300 * j;
    run_step(1'b1, 1'b0, "norm");
    has_zero = 1'b0;
    for (int i = 0; i < S; i++) if (pm_out[i*W +: W] == '0) has_zero = 1'b1;
    chk(has_zero, "R6 minimum becomes zero", pm_out, pack_mdl());

    // R9: valid held through the normalization cycle
    for (int j = 0; j < NB; j++) bms[j] = -400 + 111 * j;
    run_step(1'b1, 1'b1, "poke");

    // Sweep: mixed magnitudes, back-to-back steps, periodic normalization
    for (int n = 0; n < 400; n++) begin
      for (int j = 0; j < NB; j++) begin
        lfsr = next_rand(lfsr);
        bms[j] = int'($signed(lfsr[15:0])) >>> (4 * (lfsr[17:16]));
      end
      run_step(n % 3 == 2, n % 17 == 5, "sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule